// File: doc/BRIEF.md
# External Chip-Enable Decoder with Shared Port Pins

This block turns each bus access into three active-low chip-enable outputs for external memory. Where each chip-enable answers depends on a registered mode bit. In one mode, program memory is on chip, and chip-enable 0 serves the top megabyte of the 4 MB space. In the other mode, program memory lives outside the chip. Chip-enable 0 then serves the low megabyte, apart from a hole for the on-chip RAM and registers, so that program fetches reach the external program store through it. Chip-enables 1 and 2 always serve the second and third megabyte. The bus can flag an access as internal. Such an access never drives any chip-enable.

Each chip-enable shares its pin with one general-purpose output port bit. A per-pin select register picks whether the pin carries the port value or the chip-enable. Reset clears the select register and the mode bit, so every pin starts as a plain port output. The decode path is purely combinational. Only the configuration sits in flip-flops, and a configuration write takes effect at the next rising clock edge.

Top module: `xmem_select`

## Requirements
- R1: While reset is asserted and after it is released, all select bits and the mode bit read as 0, so each `pin_o[i]` equals `port_dout[i]` until configuration is written.
- R2: With mode bit 0, chip-enable 0 drives low for external strobed addresses 0x300000 to 0x3FFFFF. It stays high for all addresses below 0x300000 and from 0x400000 upward.
- R3: With mode bit 1, chip-enable 0 drives low for external strobed addresses 0x000000 to 0x00D7FF and 0x010000 to 0x0FFFFF. It stays high for 0x00D800 to 0x00FFFF and for addresses from 0x300000 upward.
- R4: In both modes, chip-enable 1 drives low for 0x100000 to 0x1FFFFF and chip-enable 2 drives low for 0x200000 to 0x2FFFFF.
- R5: When `bus_internal` is 1, all three chip-enables stay high, whatever the address.
- R6: When `bus_strobe` is 0, all three chip-enables stay high.
- R7: A strobed external address that falls in no window leaves every chip-enable high. A pin in chip-enable function then drives 1.
- R8: `pin_o[i]` carries chip-enable i when select bit i is 1 and `port_dout[i]` when it is 0. Pins switch independently. A write to `sel_wdata` with `sel_wr` high takes effect from the next rising clock edge.
- R9: A write to `mode_wdata` with `mode_wr` high changes the address map from the next rising clock edge. Value 1 selects the external program memory map.
- R10: At most one chip-enable is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration registers |
| rst_n | input | 1 | Active-low reset, clears select bits and mode |
| bus_addr | input | 24 | Access address |
| bus_strobe | input | 1 | High while an access is in progress |
| bus_internal | input | 1 | High when the access targets on-chip memory or registers |
| mode_wr | input | 1 | Load strobe for the mode bit |
| mode_wdata | input | 1 | New mode: 0 on-chip program, 1 external program |
| sel_wr | input | 1 | Load strobe for the pin select bits |
| sel_wdata | input | 3 | New pin select bits, 1 = chip-enable function |
| port_dout | input | 3 | Port output values for the shared pins |
| pin_o | output | 3 | Pin values driven out of the chip |

## Verification
The assertions take for granted that `bus_strobe`, `bus_internal` and `bus_addr` are settled at each rising edge. They also take for granted that the configuration write strobes are never X after reset. The stimulus changes all inputs only at falling edges and keeps the strobes at 0 or 1 throughout. Random addresses are masked mostly into the 4 MB decoded space. A smaller share uses the full 24 bits, so that the space above the windows is also driven.

// File: rtl/xsel_pkg.sv
`timescale 1ns/1ps
package xsel_pkg;
   localparam int unsigned BANK_SHIFT = 20;
   localparam int unsigned LOW_TOP    = 32'h0000_D7FF;
   localparam int unsigned EXT_LO     = 32'h0001_0000;
   localparam int unsigned EXT_HI     = 32'h000F_FFFF;

   typedef enum logic {
      PROG_ONCHIP  = 1'b0,
      PROG_OFFCHIP = 1'b1
   } prog_mode_e;
endpackage

// File: rtl/xsel_window.sv
`timescale 1ns/1ps
module xsel_window #(
   parameter int ADDR_W = 24,
   parameter logic [ADDR_W-1:0] LO = '0,
   parameter logic [ADDR_W-1:0] HI = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   if (HI < LO) begin : g_bad_bounds
      $error("xsel_window: HI below LO");
   end

   if (LO == '0) begin : g_from_zero
      assign hit = (addr <= HI);
   end else begin : g_bounded
      assign hit = (addr >= LO) && (addr <= HI);
   end
endmodule

// File: rtl/xsel_decode.sv
`timescale 1ns/1ps
module xsel_decode
   import xsel_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int NUM_CE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strobe,
   input  logic              internal,
   input  prog_mode_e        mode,
   output logic [NUM_CE-1:0] ce_act
);
   localparam logic [ADDR_W-1:0] BANK_MASK = ADDR_W'((32'd1 << BANK_SHIFT) - 1);

   logic              go;
   logic              w_onchip;
   logic              w_low;
   logic              w_ext;
   logic [NUM_CE-1:0] w_bank;

   assign go = strobe && !internal;

   // chip-enable 0 in on-chip program mode sits one bank above the last other bank
   xsel_window #(
      .ADDR_W (ADDR_W),
      .LO     (ADDR_W'(NUM_CE) << BANK_SHIFT),
      .HI     ((ADDR_W'(NUM_CE) << BANK_SHIFT) | BANK_MASK)
   ) u_win_onchip (.addr(addr), .hit(w_onchip));

   xsel_window #(
      .ADDR_W (ADDR_W),
      .LO     ('0),
      .HI     (ADDR_W'(LOW_TOP))
   ) u_win_low (.addr(addr), .hit(w_low));

   xsel_window #(
      .ADDR_W (ADDR_W),
      .LO     (ADDR_W'(EXT_LO)),
      .HI     (ADDR_W'(EXT_HI))
   ) u_win_ext (.addr(addr), .hit(w_ext));

   assign w_bank[0] = (mode == PROG_OFFCHIP) ? (w_low || w_ext) : w_onchip;

   for (genvar i = 1; i < NUM_CE; i++) begin : g_bank
      xsel_window #(
         .ADDR_W (ADDR_W),
         .LO     (ADDR_W'(i) << BANK_SHIFT),
         .HI     ((ADDR_W'(i) << BANK_SHIFT) | BANK_MASK)
      ) u_win (.addr(addr), .hit(w_bank[i]));
   end

   assign ce_act = go ? w_bank : '0;

   // R10
   ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ce_act));

   // R5
   internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      internal |-> (ce_act == '0));

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |-> (ce_act == '0));

   // R3
   ram_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PROG_OFFCHIP && addr >= ADDR_W'(LOW_TOP + 1) && addr < ADDR_W'(EXT_LO))
         |-> !ce_act[0]);
endmodule

// File: rtl/xsel_cfg.sv
`timescale 1ns/1ps
module xsel_cfg
   import xsel_pkg::*;
#(
   parameter int NUM_CE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              mode_wdata,
   input  logic              sel_wr,
   input  logic [NUM_CE-1:0] sel_wdata,
   output prog_mode_e        mode_q,
   output logic [NUM_CE-1:0] sel_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PROG_ONCHIP;
         sel_q  <= '0;
      end else begin
         if (mode_wr) mode_q <= prog_mode_e'(mode_wdata);
         if (sel_wr)  sel_q  <= sel_wdata;
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (sel_q == '0 && mode_q == PROG_ONCHIP));

   // R8
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (sel_q == $past(sel_wdata)));

   // R9
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (mode_q == prog_mode_e'($past(mode_wdata))));

   // R8
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr |=> $stable(sel_q));
endmodule

// File: rtl/xsel_pinmux.sv
`timescale 1ns/1ps
module xsel_pinmux #(
   parameter int NUM_CE = 3
) (
   input  logic [NUM_CE-1:0] sel,
   input  logic [NUM_CE-1:0] ce_act,
   input  logic [NUM_CE-1:0] port_dout,
   output logic [NUM_CE-1:0] pin_o
);
   for (genvar i = 0; i < NUM_CE; i++) begin : g_pin
      assign pin_o[i] = sel[i] ? !ce_act[i] : port_dout[i];
   end
endmodule

// File: rtl/xmem_select.sv
`timescale 1ns/1ps
module xmem_select
   import xsel_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int NUM_CE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_strobe,
   input  logic              bus_internal,
   input  logic              mode_wr,
   input  logic              mode_wdata,
   input  logic              sel_wr,
   input  logic [NUM_CE-1:0] sel_wdata,
   input  logic [NUM_CE-1:0] port_dout,
   output logic [NUM_CE-1:0] pin_o
);
   if (NUM_CE < 2 || ADDR_W <= BANK_SHIFT) begin : g_bad_shape
      $error("xmem_select: need NUM_CE >= 2 and ADDR_W > BANK_SHIFT");
   end
   if ((NUM_CE + 1) > (1 << (ADDR_W - BANK_SHIFT))) begin : g_bad_space
      $error("xmem_select: banks do not fit the address space");
   end

   prog_mode_e        mode_q;
   logic [NUM_CE-1:0] sel_q;
   logic [NUM_CE-1:0] ce_act;

   xsel_cfg #(.NUM_CE(NUM_CE)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .sel_wr     (sel_wr),
      .sel_wdata  (sel_wdata),
      .mode_q     (mode_q),
      .sel_q      (sel_q)
   );

   xsel_decode #(.ADDR_W(ADDR_W), .NUM_CE(NUM_CE)) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .strobe   (bus_strobe),
      .internal (bus_internal),
      .mode     (mode_q),
      .ce_act   (ce_act)
   );

   xsel_pinmux #(.NUM_CE(NUM_CE)) u_pinmux (
      .sel       (sel_q),
      .ce_act    (ce_act),
      .port_dout (port_dout),
      .pin_o     (pin_o)
   );

   // R7
   no_match_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_strobe && !bus_internal && bus_addr >= (ADDR_W'(NUM_CE + 1) << BANK_SHIFT))
         |-> ((pin_o & sel_q) == sel_q));
endmodule

// File: tb/xmem_select_bench.sv
`timescale 1ns/1ps
module xmem_select_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] bus_addr = '0;
   logic        bus_strobe = 1'b0;
   logic        bus_internal = 1'b0;
   logic        mode_wr = 1'b0;
   logic        mode_wdata = 1'b0;
   logic        sel_wr = 1'b0;
   logic [2:0]  sel_wdata = '0;
   logic [2:0]  port_dout = '0;
   logic [2:0]  pin_o;

   int   checks = 0;
   int   fails  = 0;
   logic m_mode = 1'b0;
   logic [2:0] m_sel = '0;

   always #2.5 clk = ~clk;

   xmem_select u_xmem_select (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
      .bus_internal(bus_internal), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .sel_wr(sel_wr), .sel_wdata(sel_wdata), .port_dout(port_dout), .pin_o(pin_o)
   );

   function automatic logic [2:0] exp_pins(logic [23:0] a, logic stb, logic intl,
                                           logic md, logic [2:0] sel, logic [2:0] port);
      logic [2:0] ce_n = 3'b111;
      logic [2:0] r;
      if (stb && !intl) begin
         if (a >= 24'h100000 && a <= 24'h1FFFFF) ce_n[1] = 1'b0;
         if (a >= 24'h200000 && a <= 24'h2FFFFF) ce_n[2] = 1'b0;
         if (md) begin
            if (a <= 24'h00D7FF || (a >= 24'h010000 && a <= 24'h0FFFFF)) ce_n[0] = 1'b0;
         end else begin
            if (a >= 24'h300000 && a <= 24'h3FFFFF) ce_n[0] = 1'b0;
         end
      end
      for (int i = 0; i < 3; i++) r[i] = sel[i] ? ce_n[i] : port[i];
      return r;
   endfunction

   task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: pin_o=%b expected %b (addr=%h stb=%b int=%b mode=%b sel=%b)",
                  tag, act, exp, bus_addr, bus_strobe, bus_internal, m_mode, m_sel);
      end
   endtask

   task automatic apply(string tag, logic [23:0] a, logic stb, logic intl, logic [2:0] port);
      @(negedge clk);
      bus_addr = a; bus_strobe = stb; bus_internal = intl; port_dout = port;
      #1;
      check(tag, pin_o, exp_pins(a, stb, intl, m_mode, m_sel, port));
   endtask

   task automatic set_mode(logic m);
      @(negedge clk);
      mode_wr = 1'b1; mode_wdata = m;
      @(negedge clk);
      mode_wr = 1'b0;
      m_mode = m;
   endtask

   task automatic set_sel(logic [2:0] s);
      @(negedge clk);
      sel_wr = 1'b1; sel_wdata = s;
      @(negedge clk);
      sel_wr = 1'b0;
      m_sel = s;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      // R1: pins follow port during reset
      @(negedge clk);
      bus_addr = 24'h100000; bus_strobe = 1'b1; port_dout = 3'b101; #1;
      check("R1 in reset", pin_o, 3'b101);
      rst_n = 1'b1;
      apply("R1 after reset", 24'h300000, 1'b1, 1'b0, 3'b010);
      apply("R1 after reset", 24'h200000, 1'b1, 1'b0, 3'b110);

      // R8: write latency
      @(negedge clk);
      sel_wr = 1'b1; sel_wdata = 3'b111;
      bus_addr = 24'h100000; bus_strobe = 1'b1; bus_internal = 1'b0; port_dout = 3'b000; #1;
      check("R8 before edge", pin_o, 3'b000);
      @(negedge clk);
      sel_wr = 1'b0; m_sel = 3'b111; #1;
      check("R8 after edge", pin_o, 3'b101);

      // R2 on-chip program map
      apply("R2", 24'h300000, 1'b1, 1'b0, 3'b000);
      apply("R2", 24'h3FFFFF, 1'b1, 1'b0, 3'b000);
      apply("R2", 24'h000000, 1'b1, 1'b0, 3'b000);
      apply("R2", 24'h0FFFFF, 1'b1, 1'b0, 3'b000);
      apply("R7", 24'h400000, 1'b1, 1'b0, 3'b000);
      apply("R7", 24'hFFFFFF, 1'b1, 1'b0, 3'b000);
      // R4 banks
      apply("R4", 24'h100000, 1'b1, 1'b0, 3'b000);
      apply("R4", 24'h1FFFFF, 1'b1, 1'b0, 3'b000);
      apply("R4", 24'h200000, 1'b1, 1'b0, 3'b000);
      apply("R4", 24'h2FFFFF, 1'b1, 1'b0, 3'b000);
      // R5, R6
      apply("R5", 24'h300010, 1'b1, 1'b1, 3'b000);
      apply("R5", 24'h150000, 1'b1, 1'b1, 3'b000);
      apply("R6", 24'h250000, 1'b0, 1'b0, 3'b000);

      // R9: mode write latency
      @(negedge clk);
      mode_wr = 1'b1; mode_wdata = 1'b1;
      bus_addr = 24'h000100; bus_strobe = 1'b1; #1;
      check("R9 before edge", pin_o, 3'b111);
      @(negedge clk);
      mode_wr = 1'b0; m_mode = 1'b1; #1;
      check("R9 after edge", pin_o, 3'b110);

      // R3 external program map
      apply("R3", 24'h000000, 1'b1, 1'b0, 3'b000);
      apply("R3", 24'h00D7FF, 1'b1, 1'b0, 3'b000);
      apply("R3", 24'h00D800, 1'b1, 1'b0, 3'b000);
      apply("R3", 24'h00FFFF, 1'b1, 1'b0, 3'b000);
      apply("R3", 24'h010000, 1'b1, 1'b0, 3'b000);
      apply("R3", 24'h0FFFFF, 1'b1, 1'b0, 3'b000);
      apply("R3", 24'h300000, 1'b1, 1'b0, 3'b000);
      apply("R3", 24'h3FFFFF, 1'b1, 1'b0, 3'b000);
      apply("R4", 24'h180000, 1'b1, 1'b0, 3'b000);
      apply("R4", 24'h280000, 1'b1, 1'b0, 3'b000);
      apply("R5", 24'h00D700, 1'b1, 1'b1, 3'b000);

      // R8 partial selection
      set_sel(3'b010);
      apply("R8", 24'h100000, 1'b1, 1'b0, 3'b101);
      apply("R8", 24'h000010, 1'b1, 1'b0, 3'b111);
      apply("R8", 24'h200000, 1'b1, 1'b0, 3'b000);
      set_sel(3'b000);
      apply("R8", 24'h100000, 1'b1, 1'b0, 3'b011);

      // random phase
      for (int k = 0; k < 600; k++) begin
         logic [23:0] a;
         logic stb, intl;
         logic [2:0] port;
         string tag;
         if (k % 50 == 0) set_mode(1'($urandom));
         if (k % 37 == 0) set_sel(3'($urandom));
         a = 24'($urandom);
         if (($urandom % 8) != 0) a = a & 24'h3FFFFF;
         stb  = (($urandom % 8) != 0);
         intl = (($urandom % 6) == 0);
         port = 3'($urandom);
         if (intl)        tag = "R5 random";
         else if (!stb)   tag = "R6 random";
         else if (m_mode) tag = "R3 random";
         else             tag = "R2 random";
         apply(tag, a, stb, intl, port);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule